// File: doc/BRIEF.md
# Protected register bank on an APB completer port

This block sits on the peripheral bus as a completer and holds eight 32-bit registers. A requester writes and reads them with ordinary two-phase APB transfers. The write strobes pick which byte lanes of a register a write changes. A side input sets how many wait cycles the block adds to the access phase of each transfer.

Two cases end a transfer with an error. The first is an access to a word address beyond the eight registers. The second is a write to the guarded register (word 7) by an access that is not both privileged and secure. In either case no register changes. An unmapped read returns zero.

The block registers nothing at its edge. Read data and the error flag come from the decoded address and the register contents in the cycle the transfer completes. Register updates take effect on the clock edge that ends the completing cycle.

Top module: `apb_regbank`

## Requirements
- R1: While `rst_n` is low at a clock edge, all eight registers clear to zero. `pready`, `pslverr` and `prdata` are zero outside an access phase.
- R2: On a completed write, byte lane i of the addressed register (bits 8i+7..8i) takes `pwdata` lane i when `pstrb[i]` is 1. It keeps its old value when `pstrb[i]` is 0.
- R3: The access phase lasts exactly `wait_cnt`+1 cycles. `pready` is low in the earlier cycles and high in the last one. A zero count completes in the first access cycle. `wait_cnt` is sampled in the first access cycle.
- R4: A register changes only on a completing write cycle (psel, penable and pready all high). A write abandoned by dropping `psel` during wait cycles leaves the register unchanged.
- R5: `pslverr` is high only in a completing cycle. It is low in setup cycles, wait cycles and idle cycles.
- R6: Word 7 (byte address 0x1C) accepts a write only when `pprot[0]`=1 (privileged) and `pprot[1]`=0 (secure). Any other write to it ends with `pslverr`=1 and leaves it unchanged. Reads of it succeed under any `pprot`, and `pprot[2]` has no effect anywhere.
- R7: Word indices 8 to 15 (`paddr[5:2]` ≥ 8) are unmapped. A transfer to one ends with `pslverr`=1, a read of one returns zero, and a write to one changes no register.
- R8: In a completing read of a mapped word, `prdata` equals that register. In every other cycle it is zero. `paddr[1:0]` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| psel | input | 1 | Completer select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 6 | Byte address; bits 5:2 select the word |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Byte-lane write enables |
| pprot | input | 3 | Protection: bit0 privileged, bit1 non-secure, bit2 instruction |
| wait_cnt | input | 4 | Wait cycles to add to each access phase |
| prdata | output | 32 | Read data, valid in the completing read cycle |
| pready | output | 1 | High in the completing access cycle |
| pslverr | output | 1 | Error, high only in a completing cycle |

## Verification
`pready`, `pslverr` and `prdata` are combinational. They are due in the same cycle as the access state that produces them: `pready` in access cycle `wait_cnt`+1, and the response in that same cycle. Register contents change at the edge that closes the completing cycle, so the bench observes them only through a later read transfer. The bench drives inputs at the falling edge and samples one nanosecond later. It counts access cycles until `pready` rises, and it checks `pslverr` and `prdata` in every setup and wait cycle as well as at completion.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned ADDR_W   = 6;
    localparam int unsigned NUM_REGS = 8;
    localparam int unsigned PROT_REG = 7;
    localparam int unsigned WAIT_W   = 4;
    localparam int unsigned LANES    = DATA_W / 8;
    localparam int unsigned IDX_W    = ADDR_W - 2;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef struct packed {
        idx_t idx;
        logic mapped;
        logic denied;
    } dec_t;

    function automatic word_t merge_lanes(word_t old_w, word_t new_w, logic [LANES-1:0] strb);
        word_t res;
        for (int i = 0; i < LANES; i++)
            res[8*i +: 8] = strb[i] ? new_w[8*i +: 8] : old_w[8*i +: 8];
        return res;
    endfunction

    function automatic logic prot_allows(logic [2:0] prot);
        return prot[0] && !prot[1];
    endfunction
endpackage

// File: rtl/regbank_wait.sv
module regbank_wait
    import regbank_pkg::*;
#(
    parameter int unsigned CNT_W = WAIT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             access,
    input  logic [CNT_W-1:0] wait_cnt,
    output logic             ready
);
    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    always_comb ready = access && (busy_q ? (cnt_q == '0) : (wait_cnt == '0));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!access || ready) begin
            busy_q <= 1'b0;
        end else if (!busy_q) begin
            busy_q <= 1'b1;
            cnt_q  <= wait_cnt - 1'b1;
        end else begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    property p_no_early_ready;
        @(posedge clk) disable iff (!rst_n)
        (access && busy_q && cnt_q > 1) |=> !ready;
    endproperty
    assert_no_early_ready_R3: assert property (p_no_early_ready);
endmodule

// File: rtl/regbank_decode.sv
module regbank_decode
    import regbank_pkg::*;
(
    input  logic [ADDR_W-1:0] paddr,
    input  logic              pwrite,
    input  logic [2:0]        pprot,
    output dec_t              dec
);
    logic unused_dec;
    assign unused_dec = ^{paddr[1:0], pprot[2]};

    always_comb begin
        dec.idx    = paddr[ADDR_W-1:2];
        dec.mapped = (32'(dec.idx) < NUM_REGS);
        dec.denied = !dec.mapped ||
                     (pwrite && 32'(dec.idx) == PROT_REG && !prot_allows(pprot));
    end
endmodule

// File: rtl/regbank_store.sv
module regbank_store
    import regbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  idx_t             idx,
    input  word_t            wdata,
    input  logic [LANES-1:0] wstrb,
    output word_t            rword
);
    word_t regs_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[g] <= '0;
            else if (we && 32'(idx) == g)
                regs_q[g] <= merge_lanes(regs_q[g], wdata, wstrb);
        end

        property p_hold;
            @(posedge clk) disable iff (!rst_n)
            !(we && 32'(idx) == g) |=> $stable(regs_q[g]);
        endproperty
        assert_reg_hold_R4: assert property (p_hold);
    end

    always_comb rword = (32'(idx) < NUM_REGS) ? regs_q[idx[$clog2(NUM_REGS)-1:0]] : '0;
endmodule

// File: rtl/apb_regbank.sv
module apb_regbank
    import regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [LANES-1:0]  pstrb,
    input  logic [2:0]        pprot,
    input  logic [WAIT_W-1:0] wait_cnt,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr
);
    logic  access, ready, done, we;
    dec_t  dec;
    word_t rword;

    assign access = psel && penable;

    regbank_wait #(.CNT_W(WAIT_W)) u_wait (
        .clk(clk), .rst_n(rst_n), .access(access), .wait_cnt(wait_cnt), .ready(ready)
    );

    regbank_decode u_dec (
        .paddr(paddr), .pwrite(pwrite), .pprot(pprot), .dec(dec)
    );

    assign done = access && ready;
    assign we   = done && pwrite && !dec.denied;

    regbank_store u_store (
        .clk(clk), .rst_n(rst_n), .we(we), .idx(dec.idx),
        .wdata(pwdata), .wstrb(pstrb), .rword(rword)
    );

    assign pready  = ready;
    assign pslverr = done && dec.denied;
    assign prdata  = (done && !pwrite && !dec.denied) ? rword : '0;

    property p_err_window;
        @(posedge clk) disable iff (!rst_n)
        pslverr |-> (psel && penable && pready);
    endproperty
    assert_err_window_R5: assert property (p_err_window);

    property p_guard;
        @(posedge clk) disable iff (!rst_n)
        (done && pwrite && paddr[ADDR_W-1:2] == IDX_W'(PROT_REG) && (!pprot[0] || pprot[1]))
            |-> pslverr;
    endproperty
    assert_guard_err_R6: assert property (p_guard);

    property p_unmapped;
        @(posedge clk) disable iff (!rst_n)
        (done && 32'(paddr[ADDR_W-1:2]) >= NUM_REGS) |-> (pslverr && prdata == '0);
    endproperty
    assert_unmapped_R7: assert property (p_unmapped);

    property p_rdata_idle;
        @(posedge clk) disable iff (!rst_n)
        !(psel && penable && pready) |-> prdata == '0;
    endproperty
    assert_rdata_idle_R8: assert property (p_rdata_idle);
endmodule

// File: tb/sim_apb_regbank.sv
module sim_apb_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [5:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [3:0]  pstrb = '0;
    logic [2:0]  pprot = '0;
    logic [3:0]  wait_cnt = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;

    int nchk = 0, nfail = 0;
    logic [31:0] model [8];

    always #2 clk = ~clk;

    apb_regbank u0 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .pprot(pprot), .wait_cnt(wait_cnt),
        .prdata(prdata), .pready(pready), .pslverr(pslverr)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic xfer(input logic wr, input logic [5:0] addr, input logic [31:0] wd,
                        input logic [3:0] strb, input logic [2:0] prot, input logic [3:0] wt,
                        input int abort_after,
                        output logic [31:0] rd, output logic err, output int cyc);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = wr; paddr = addr; pwdata = wd;
        pstrb = strb; pprot = prot; wait_cnt = wt;
        #1;
        check(pslverr == 0 && pready == 0 && prdata == 0, "R5 setup", {30'd0, pready, pslverr}, 0);
        @(negedge clk);
        penable = 1; cyc = 0; rd = '0; err = 0;
        while (1) begin
            #1;
            cyc++;
            if (pready) begin
                rd = prdata; err = pslverr;
                break;
            end
            check(pslverr == 0 && prdata == 0, "R5 wait", {31'd0, pslverr}, 0);
            if (abort_after == cyc) break;
            if (cyc > 40) break;
            @(negedge clk);
            wait_cnt = 4'hF;
        end
        @(negedge clk);
        psel = 0; penable = 0; wait_cnt = 0;
        #1;
        check(pready == 0 && pslverr == 0 && prdata == 0, "R1 idle", prdata, 0);
    endtask

    initial begin
        #(4 * 150000);
        nfail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] rd, d;
        logic err;
        int cyc;
        logic [3:0] wt;
        for (int i = 0; i < 8; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        #1;
        check(pready == 0 && pslverr == 0 && prdata == 0, "R1 reset outputs", prdata, 0);
        @(negedge clk); rst_n = 1;

        for (int r = 0; r < 8; r++) begin
            xfer(0, 6'(r*4), 0, 0, 3'b000, 0, 0, rd, err, cyc);
            check(rd == 0 && !err, "R1 reset contents", rd, 0);
        end

        for (int r = 0; r < 8; r++) begin
            for (int s = 0; s < 16; s++) begin
                d = 32'hA55A_3CC3 ^ (32'(r) * 32'h0101_0101) ^ (32'(s) * 32'h0011_2233);
                wt = 4'((r + s) % 4);
                xfer(1, 6'(r*4), d, 4'(s), 3'b001, wt, 0, rd, err, cyc);
                check(cyc == int'(wt) + 1, "R3 write wait", 32'(cyc), 32'(wt) + 1);
                check(!err, "R5 write ok", {31'd0, err}, 0);
                check(rd == 0, "R8 write prdata", rd, 0);
                for (int b = 0; b < 4; b++) if (s[b]) model[r][8*b +: 8] = d[8*b +: 8];
                wt = 4'(s % 3);
                xfer(0, 6'(r*4 + (s % 4)), 0, 0, 3'(s % 8), wt, 0, rd, err, cyc);
                check(rd == model[r], "R2 lane merge", rd, model[r]);
                check(cyc == int'(wt) + 1, "R3 read wait", 32'(cyc), 32'(wt) + 1);
                check(!err, "R8 read ok", {31'd0, err}, 0);
            end
        end

        for (int p = 0; p < 8; p++) begin
            d = 32'h1357_9BDF + 32'(p) * 32'h1111;
            xfer(1, 6'h1C, d, 4'hF, 3'(p), 4'(p % 2), 0, rd, err, cyc);
            check(err == !(p[0] && !p[1]), "R6 guard error", {31'd0, err}, {31'd0, !(p[0] && !p[1])});
            if (p[0] && !p[1]) model[7] = d;
            xfer(0, 6'h1C, 0, 0, 3'(p), 0, 0, rd, err, cyc);
            check(rd == model[7] && !err, "R6 guard contents", rd, model[7]);
        end

        for (int i = 8; i < 16; i++) begin
            xfer(1, 6'(i*4), 32'hFFFF_FFFF, 4'hF, 3'b001, 4'(i % 3), 0, rd, err, cyc);
            check(err, "R7 unmapped write error", {31'd0, err}, 1);
            check(cyc == (i % 3) + 1, "R3 unmapped wait", 32'(cyc), 32'((i % 3) + 1));
            xfer(0, 6'(i*4 + 1), 0, 0, 3'b000, 1, 0, rd, err, cyc);
            check(err && rd == 0, "R7 unmapped read", rd, 0);
        end
        for (int r = 0; r < 8; r++) begin
            xfer(0, 6'(r*4), 0, 0, 3'b000, 0, 0, rd, err, cyc);
            check(rd == model[r], "R7 no side effect", rd, model[r]);
        end

        xfer(1, 6'h0C, 32'hDEAD_BEEF, 4'hF, 3'b001, 3, 2, rd, err, cyc);
        check(cyc == 2 && !err, "R4 abort no completion", 32'(cyc), 2);
        xfer(0, 6'h0C, 0, 0, 3'b000, 0, 0, rd, err, cyc);
        check(rd == model[3], "R4 aborted write", rd, model[3]);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule